// File: doc/BRIEF.md
# Zoned External Bus Timing Controller

This block is the master side of an asynchronous parallel memory bus. A requester presents a read or write with a zone number, an address and write data. The controller runs the external cycle in three phases: lead, active and trail. It drives one chip select per zone, a read/write direction line, a write strobe, the address and the outgoing data. Read data is captured on the bus and returned to the requester with a one-cycle done pulse.

Each zone keeps its own timing word. The word holds separate lead, active and trail counts for reads and for writes, a doubling flag, a ready-handshake enable and a bus-width code. One zone can be marked as slow. Idle gap cycles are then inserted before any access that moves into or out of that zone, so a slow device gets time to release the bus before the next device drives it. All counts are in cycles of the block clock.

Top module: `ext_bus_timer`

## Requirements
- R1: After reset all chip selects are high, the write strobe is high, the direction line is high (read), `req_ready` is high and `done` is low. Every zone then holds counts of 3, doubling on, ready off and a 16-bit width, so each phase lasts 6 cycles.
- R2: During an access, exactly the addressed zone's chip select is low, for lead + active + trail cycles. The counts are taken from the read set or the write set according to the access type. The write strobe is low only in the active phase of a write, so its first low cycle is cycle lead + 1 of the chip-select window.
- R3: When a zone's doubling flag is set, every lead, active and trail duration of that zone is twice its programmed count. With the flag clear, a count of 1 gives a one-cycle phase.
- R4: The timing word `cfg_wdata` is laid out as follows: [2:0] read lead, [5:3] read active, [8:6] read trail, [11:9] write lead, [14:12] write active, [17:15] write trail, [18] doubling, [19] ready enable, [21:20] width code. A write is rejected if either lead count is 0, if the width code is not 3 or 1, or if ready is enabled while either active count is 0. A rejected write leaves the zone's old timing in force, and `cfg_err` is high for one cycle after any rejected write and low after an accepted one.
- R5: Width code 3 means 16 bits: only `bus_dout[15:0]` carries write data, with the upper half driven to 0, and `rd_data[31:16]` is returned as 0. Width code 1 means 32 bits on both paths.
- R6: In a ready-enabled zone, once the programmed active count has elapsed, the active phase is extended by one cycle for every cycle in which `bus_rdy` is sampled low. The phase ends after the first cycle with `bus_rdy` high.
- R7: The bank setting names one zone and an idle count. When an access goes from a zone outside that zone into it, or from inside it out, that many idle cycles with all chip selects high come before the lead phase. No idle cycles are added between two accesses on the same side.
- R8: `rd_data` holds the `bus_din` value sampled in the last active cycle of a read. `done` is high for one cycle, in the cycle right after the final trail cycle. `req_ready` is high only while no access is in progress.
- R9: The direction line is low for the whole chip-select window of a write and high for a read. The address holds still while a chip select stays low.
- R10: In a zone without ready, an active count of 0 gives a cycle with no write strobe at all, lasting lead + trail cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and bus timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write a zone timing word |
| cfg_zone | input | ZW | Zone addressed by the timing write |
| cfg_wdata | input | CFGW | Timing word, laid out as in R4 |
| cfg_err | output | 1 | Previous timing write was rejected |
| bank_we | input | 1 | Load the slow-zone setting |
| bank_zone | input | ZW | Slow zone number |
| bank_idle | input | IW | Idle cycles inserted on crossings |
| req_valid | input | 1 | Access request, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | ZW | Target zone |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| cs_n | output | NZONES | Active-low chip select per zone |
| rnw | output | 1 | Bus direction, low during writes |
| we_n | output | 1 | Active-low write strobe |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_oe | output | 1 | Write data output enable |
| bus_din | input | DW | External read data |
| bus_rdy | input | 1 | Device ready input |

## Verification
The embedded properties watch, on every cycle, that at most one chip select is low and that the strobe only falls inside a write window. They also check that the strobe is never low in the first cycle of a window, that the address holds while a chip select stays low, that `done` never lasts two cycles, and that a low ready on the last active cycle keeps the active phase going. The exact lengths of each phase, the effect of doubling, the rejection of bad timing words, the width masking, the captured read value and the idle gaps on slow-zone crossings depend on programmed values. Only the bench's directed scenarios show these, by counting cycles at the pins.

// File: rtl/ext_bus_timer.sv
module ext_bus_timer #(
  parameter int NZONES = 4,
  parameter int AW     = 20,
  parameter int DW     = 32,
  parameter int CW     = 3,
  parameter int IW     = 3,
  localparam int ZW    = (NZONES > 1) ? $clog2(NZONES) : 1,
  localparam int CFGW  = 6 * CW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ZW-1:0]     cfg_zone,
  input  logic [CFGW-1:0]   cfg_wdata,
  output logic              cfg_err,
  input  logic              bank_we,
  input  logic [ZW-1:0]     bank_zone,
  input  logic [IW-1:0]     bank_idle,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ZW-1:0]     req_zone,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [NZONES-1:0] cs_n,
  output logic              rnw,
  output logic              we_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);

  localparam int HW    = DW / 2;
  localparam int DBL_B = 6 * CW;
  localparam int RDY_B = 6 * CW + 1;
  localparam int SZ_B  = 6 * CW + 2;
  localparam int CNTW  = (CW + 1 > IW) ? CW + 1 : IW;
  localparam logic [CFGW-1:0] CFG_RST = {2'b11, 1'b0, 1'b1, {6{CW'(3)}}};

  typedef enum logic [2:0] {S_IDLE, S_BANK, S_LEAD, S_ACT, S_TRAIL} st_t;

  function automatic logic [CW-1:0] fld(input logic [CFGW-1:0] c, input int idx);
    return c[idx*CW +: CW];
  endfunction

  function automatic logic [CW:0] plen(input logic [CW-1:0] v, input logic dbl);
    return dbl ? {v, 1'b0} : {1'b0, v};
  endfunction

  logic [CFGW-1:0] zcfg [NZONES];
  logic [ZW-1:0]   slow_zone;
  logic [IW-1:0]   slow_idle;

  st_t             st, st_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic            done_n, cap, ld, fin_strobe;
  logic            has_prev;
  logic [ZW-1:0]   cur_zone;
  logic            cur_wr, cur_rdy, cur_w16;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   cur_wdata;
  logic [CW:0]     cur_lead, cur_act, cur_trl;

  // Timing word check
  logic [1:0] cfg_sz;
  logic       cfg_ok;
  assign cfg_sz = cfg_wdata[SZ_B +: 2];
  assign cfg_ok = (fld(cfg_wdata, 0) != '0) && (fld(cfg_wdata, 3) != '0) &&
                  (cfg_sz == 2'd3 || cfg_sz == 2'd1) &&
                  !(cfg_wdata[RDY_B] && (fld(cfg_wdata, 1) == '0 || fld(cfg_wdata, 4) == '0));

  // Timing of the incoming request
  logic [CFGW-1:0] rq_cfg;
  logic [CW:0]     rq_lead, rq_act, rq_trl;
  logic            rq_cross;
  assign rq_cfg   = zcfg[req_zone];
  assign rq_lead  = plen(fld(rq_cfg, req_write ? 3 : 0), rq_cfg[DBL_B]);
  assign rq_act   = plen(fld(rq_cfg, req_write ? 4 : 1), rq_cfg[DBL_B]);
  assign rq_trl   = plen(fld(rq_cfg, req_write ? 5 : 2), rq_cfg[DBL_B]);
  assign rq_cross = has_prev && ((req_zone == slow_zone) != (cur_zone == slow_zone));

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    done_n     = 1'b0;
    cap        = 1'b0;
    ld         = 1'b0;
    fin_strobe = 1'b0;
    unique case (st)
      S_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (rq_cross && slow_idle != '0) begin
          st_n  = S_BANK;
          cnt_n = CNTW'(slow_idle) - CNTW'(1);
        end else begin
          st_n  = S_LEAD;
          cnt_n = CNTW'(rq_lead) - CNTW'(1);
        end
      end
      S_BANK: if (cnt == '0) begin
        st_n  = S_LEAD;
        cnt_n = CNTW'(cur_lead) - CNTW'(1);
      end else cnt_n = cnt - CNTW'(1);
      S_LEAD: if (cnt == '0) begin
        if (cur_act != '0) begin
          st_n  = S_ACT;
          cnt_n = CNTW'(cur_act) - CNTW'(1);
        end else fin_strobe = 1'b1;
      end else cnt_n = cnt - CNTW'(1);
      S_ACT: if (cnt != '0) cnt_n = cnt - CNTW'(1);
             else if (!(cur_rdy && !bus_rdy)) fin_strobe = 1'b1;
      S_TRAIL: if (cnt == '0) begin
        st_n   = S_IDLE;
        done_n = 1'b1;
      end else cnt_n = cnt - CNTW'(1);
      default: st_n = S_IDLE;
    endcase
    if (fin_strobe) begin
      cap = !cur_wr;
      if (cur_trl != '0) begin
        st_n  = S_TRAIL;
        cnt_n = CNTW'(cur_trl) - CNTW'(1);
      end else begin
        st_n   = S_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
      rd_data   <= '0;
      has_prev  <= 1'b0;
      cur_zone  <= '0;
      cur_wr    <= 1'b0;
      cur_rdy   <= 1'b0;
      cur_w16   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_lead  <= '0;
      cur_act   <= '0;
      cur_trl   <= '0;
      slow_zone <= '0;
      slow_idle <= '0;
      for (int z = 0; z < NZONES; z++) zcfg[z] <= CFG_RST;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      done    <= done_n;
      cfg_err <= cfg_we && !cfg_ok;
      if (cfg_we && cfg_ok && int'(cfg_zone) < NZONES) zcfg[cfg_zone] <= cfg_wdata;
      if (bank_we) begin
        slow_zone <= bank_zone;
        slow_idle <= bank_idle;
      end
      if (ld) begin
        has_prev  <= 1'b1;
        cur_zone  <= req_zone;
        cur_wr    <= req_write;
        cur_rdy   <= rq_cfg[RDY_B];
        cur_w16   <= (rq_cfg[SZ_B +: 2] == 2'd3);
        cur_addr  <= req_addr;
        cur_wdata <= (rq_cfg[SZ_B +: 2] == 2'd3) ? {{(DW-HW){1'b0}}, req_wdata[HW-1:0]} : req_wdata;
        cur_lead  <= rq_lead;
        cur_act   <= rq_act;
        cur_trl   <= rq_trl;
      end
      if (cap) rd_data <= cur_w16 ? {{(DW-HW){1'b0}}, bus_din[HW-1:0]} : bus_din;
    end
  end

  logic busy;
  assign busy      = (st == S_LEAD) || (st == S_ACT) || (st == S_TRAIL);
  assign req_ready = (st == S_IDLE);
  assign rnw       = !(busy && cur_wr);
  assign we_n      = !(st == S_ACT && cur_wr);
  assign bus_oe    = busy && cur_wr;
  assign bus_addr  = cur_addr;
  assign bus_dout  = cur_wdata;

  for (genvar z = 0; z < NZONES; z++) begin : g_cs
    assign cs_n[z] = !(busy && cur_zone == ZW'(z));
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R2
  AST_STROBE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!rnw && !(&cs_n))); // R9
  AST_LEAD_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&cs_n) |-> we_n); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && $past(!(&cs_n))) |-> $stable(bus_addr)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && cnt == '0 && cur_rdy && !bus_rdy) |=> (st == S_ACT)); // R6

endmodule

// File: tb/ext_bus_timer_tb.sv
module ext_bus_timer_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] DIN_BASE = 32'h5A5A_1200;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, bank_we = 0, req_valid = 0, req_write = 0, bus_rdy = 1;
  logic [1:0]  cfg_zone = 0, bank_zone = 0, req_zone = 0;
  logic [21:0] cfg_wdata = 0;
  logic [2:0]  bank_idle = 0;
  logic [19:0] req_addr = 0;
  logic [31:0] req_wdata = 0, bus_din = 0;
  logic        cfg_err, req_ready, done, rnw, we_n, bus_oe;
  logic [31:0] rd_data, bus_dout;
  logic [3:0]  cs_n;
  logic [19:0] bus_addr;

  ext_bus_timer u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int r_cs, r_we, r_pre, r_wefirst, r_badcs, r_badrnw;
  logic [31:0] r_data, r_dout;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic logic [21:0] mk(int rl, int ra, int rt, int wl, int wa, int wt,
                                     bit dbl, bit rdy, int sz);
    return {2'(sz), rdy, dbl, 3'(wt), 3'(wa), 3'(wl), 3'(rt), 3'(ra), 3'(rl)};
  endfunction

  task automatic cfgw(input int zone, input logic [21:0] w, input bit exp_err, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_zone = 2'(zone); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
    chk({tag, " cfg_err"}, cfg_err, exp_err);
  endtask

  task automatic access(input int zone, input bit wr, input logic [19:0] addr,
                        input logic [31:0] wd, input int stall_at);
    bit seen = 0;
    bit fin = 0;
    r_cs = 0; r_we = 0; r_pre = 0; r_wefirst = 0; r_badcs = 0; r_badrnw = 0;
    r_data = 'x; r_dout = 'x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_zone = 2'(zone); req_addr = addr; req_wdata = wd;
    bus_rdy = (stall_at < 0);
    @(negedge clk);
    req_valid = 0;
    for (int g = 0; g < 400 && !fin; g++) begin
      if (!(&cs_n)) begin
        seen = 1;
        r_cs++;
        if (cs_n != ~(4'b1 << zone)) r_badcs++;
        if (rnw == wr) r_badrnw++;
        if (bus_addr != addr) r_badcs++;
        bus_din = DIN_BASE + 32'(r_cs);
      end else if (!seen) r_pre++;
      if (!we_n) begin
        r_we++;
        if (r_wefirst == 0) begin r_wefirst = r_cs; r_dout = bus_dout; end
        if (stall_at >= 0 && r_we == stall_at) bus_rdy = 1;
      end
      if (done) begin
        r_data = rd_data; fin = 1;
      end else @(negedge clk);
    end
    if (!fin) chk("R8 access timeout", 0, 1);
    bus_rdy = 1;
  endtask

  task automatic t_reset;
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 we_n", we_n, 1);
    chk("R1 rnw", rnw, 1);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 done", done, 0);
    access(0, 0, 20'h00010, 0, -1);
    chk("R1 default cycle", r_cs, 18);
    chk("R5 default 16-bit read", r_data, (DIN_BASE + 12) & 32'hFFFF);
    chk("R8 ready low in cycle", req_ready, 1);
  endtask

  task automatic t_split_sets;
    cfgw(1, mk(1, 2, 1, 2, 3, 4, 0, 0, 1), 0, "R4 valid");
    access(1, 1, 20'hABCDE, 32'hCAFE_1234, -1);
    chk("R2 write window", r_cs, 9);
    chk("R2 write strobe", r_we, 3);
    chk("R2 strobe start", r_wefirst, 3);
    chk("R9 select/addr", r_badcs, 0);
    chk("R9 direction on write", r_badrnw, 0);
    chk("R5 32-bit dout", r_dout, 32'hCAFE_1234);
    access(1, 0, 20'h00123, 0, -1);
    chk("R2 read window", r_cs, 4);
    chk("R2 read no strobe", r_we, 0);
    chk("R9 direction on read", r_badrnw, 0);
    chk("R8 captured data", r_data, DIN_BASE + 3);
    chk("R5 32-bit read", r_data[31:16], DIN_BASE[31:16]);
  endtask

  task automatic t_double;
    cfgw(2, mk(1, 1, 1, 1, 1, 1, 1, 0, 3), 0, "R3 cfg");
    access(2, 0, 20'h00002, 0, -1);
    chk("R3 doubled read", r_cs, 6);
    chk("R8 doubled capture", r_data, (DIN_BASE + 4) & 32'hFFFF);
    access(2, 1, 20'h00003, 32'hDEAD_BEEF, -1);
    chk("R3 doubled strobe", r_we, 2);
    chk("R5 16-bit dout", r_dout, 32'h0000_BEEF);
    cfgw(3, mk(1, 1, 1, 1, 1, 1, 0, 0, 1), 0, "R3 cfg single");
    access(3, 0, 20'h00004, 0, -1);
    chk("R3 single-cycle phases", r_cs, 3);
  endtask

  task automatic t_reject;
    cfgw(1, mk(0, 2, 1, 2, 3, 4, 0, 0, 1), 1, "R4 read lead 0");
    cfgw(1, mk(1, 2, 1, 0, 3, 4, 0, 0, 1), 1, "R4 write lead 0");
    cfgw(1, mk(1, 2, 1, 2, 3, 4, 0, 0, 2), 1, "R4 size 2");
    cfgw(1, mk(1, 2, 1, 2, 3, 4, 0, 0, 0), 1, "R4 size 0");
    cfgw(1, mk(1, 2, 1, 2, 0, 4, 0, 1, 1), 1, "R4 ready active 0");
    access(1, 0, 20'h00005, 0, -1);
    chk("R4 old read timing kept", r_cs, 4);
    access(1, 1, 20'h00006, 32'h1, -1);
    chk("R4 old write timing kept", r_cs, 9);
  endtask

  task automatic t_ready;
    cfgw(3, mk(1, 1, 1, 1, 2, 1, 0, 1, 1), 0, "R6 cfg");
    access(3, 1, 20'h00007, 32'h7, 5);
    chk("R6 stretched strobe", r_we, 5);
    chk("R6 stretched window", r_cs, 7);
    access(3, 1, 20'h00008, 32'h8, 2);
    chk("R6 ready at minimum", r_we, 2);
    chk("R6 window at minimum", r_cs, 4);
  endtask

  task automatic t_zero_active;
    cfgw(3, mk(1, 1, 1, 1, 0, 2, 0, 0, 1), 0, "R10 cfg");
    access(3, 1, 20'h00009, 32'h9, -1);
    chk("R10 no strobe", r_we, 0);
    chk("R10 lead+trail", r_cs, 3);
  endtask

  task automatic t_bank;
    @(negedge clk);
    bank_we = 1; bank_zone = 0; bank_idle = 3;
    @(negedge clk);
    bank_we = 0;
    access(1, 0, 20'h00010, 0, -1);
    chk("R7 outside to outside", r_pre, 0);
    access(0, 0, 20'h00011, 0, -1);
    chk("R7 into slow zone", r_pre, 3);
    chk("R7 slow zone cycle", r_cs, 18);
    access(0, 1, 20'h00012, 32'h12, -1);
    chk("R7 inside to inside", r_pre, 0);
    access(2, 0, 20'h00013, 0, -1);
    chk("R7 out of slow zone", r_pre, 3);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk("R8 watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_split_sets();
    t_double();
    t_reject();
    t_ready();
    t_zero_active();
    t_bank();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule